// File: doc/BRIEF.md
# Two-Master Bus Arbiter with External Takeover

This block decides which of two on-chip bus masters, a processor core and a data-transfer engine, owns the shared internal bus, and separately decides whether an off-chip device may take over the external bus. Each internal master drives a request line and a flag that tells whether the access it wants goes to the external bus. It receives an acknowledge. A master owns the bus for as long as its acknowledge stays high. An off-chip device asks for the external bus on its own request line and receives its own acknowledge.

There are two priority levels. Between the internal masters, the data-transfer engine wins over the processor. Against the external takeover, any internal access that needs the external bus loses when both arise together. An access that stays on-chip is not affected by the takeover, so it runs alongside it. The takeover is switched off when the chip sleeps with the module-stop mask at one of two all-stopped patterns. All acknowledges are registered. A request sampled at a rising edge can raise its acknowledge at that edge at the earliest. No stream data passes through the block, so every pin is a plain level control signal. There is no valid/ready back-pressure. A master that is stalled simply keeps its request high until the acknowledge arrives.

A master must hold its external-access flag steady for as long as its request is high. It may drop its request at any time. A request dropped before any acknowledge is a withdrawn request.

Top module: `busown_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three acknowledges are low after that edge.
- R2: When no internal master owns the bus and an eligible master requests, its acknowledge is high after the next rising edge.
- R3: When neither internal master owns the bus and both request eligibly at the same edge, `dtc_ack` rises and `cpu_ack` stays low.
- R4: An internal master whose acknowledge is high keeps it while its request stays high, even if the other master requests. The acknowledge falls at the first edge that samples the request low, and at that same edge a waiting master can be granted.
- R5: `cpu_ack` and `dtc_ack` are never high in the same cycle.
- R6: When an external takeover request and an internal master's external-access request (`*_ext` = 1) arrive together with nothing external in progress, `xrel_ack` rises and the internal master's acknowledge stays low.
- R7: A request with `*_ext` = 0 is granted by the internal rules regardless of `xrel_req`/`xrel_ack`.
- R8: While an internal master holds an acknowledged external access, `xrel_ack` stays low. It can rise at the first edge after that master's request is low.
- R9: An external-access request stalled by an active takeover is granted at the edge that samples `xrel_req` low, provided no other internal master owns the bus.
- R10: When `sleep_i` = 1 and `stop_mask` equals 24'hFFFFFF or 24'hEFFFFF, `xrel_ack` is low after the next edge. For any other mask value, or when `sleep_i` = 0, the takeover operates normally.
- R11: Once high, `xrel_ack` stays high while `xrel_req` stays high and the halt condition of R10 is absent. It falls at the first edge that samples `xrel_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor requests the bus |
| cpu_ext | input | 1 | Processor access targets the external bus |
| cpu_ack | output | 1 | Processor owns the bus |
| dtc_req | input | 1 | Data-transfer engine requests the bus |
| dtc_ext | input | 1 | Data-transfer access targets the external bus |
| dtc_ack | output | 1 | Data-transfer engine owns the bus |
| xrel_req | input | 1 | Off-chip device asks for the external bus |
| xrel_ack | output | 1 | External bus handed to the off-chip device |
| sleep_i | input | 1 | Chip is in sleep mode |
| stop_mask | input | MASK_W (24) | Module-stop mask, compared with the two halt patterns |

## Verification
The bench builds the block with its default 24-bit mask and the two default halt patterns. This lets it drive both halt patterns exactly, and also drive near-miss masks that differ in a single bit, which must leave the takeover working. Directed sequences cover the tie between the two levels, concurrent on-chip work during a takeover, and the stall and release of an external access. A long pseudo-random phase then mixes overlapping requests, flag values and sleep/mask changes under the request-hold rules. A behavioural model compares all three acknowledges on every cycle.

// File: rtl/busown_pkg.sv
package busown_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DTC  = 2'd2
  } own_e;
endpackage

// File: rtl/busown_release.sv
module busown_release #(
  parameter int unsigned       MASK_W     = 24,
  parameter logic [MASK_W-1:0] STOP_ALL_A = 24'hFFFFFF,
  parameter logic [MASK_W-1:0] STOP_ALL_B = 24'hEFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xrel_req,
  input  logic              sleep_i,
  input  logic [MASK_W-1:0] stop_mask,
  input  logic              hold_ext,
  output logic              rel_next,
  output logic              rel_ack
);
  logic halted;
  logic rel_q;

  assign halted = sleep_i && ((stop_mask == STOP_ALL_A) || (stop_mask == STOP_ALL_B));

  // A takeover already granted stays; a new one waits for any external access in progress.
  assign rel_next = !halted && xrel_req && (rel_q || !hold_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= rel_next;
  end

  assign rel_ack = rel_q;

  // R10
  halt_blocks_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !rel_ack);

  // R11
  release_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ack && xrel_req && !halted) |=> rel_ack);

  // R11
  release_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xrel_req |=> !rel_ack);
endmodule

// File: rtl/busown_select.sv
module busown_select
  import busown_pkg::*;
#(
  parameter int unsigned MASTERS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MASTERS-1:0] req,
  input  logic [MASTERS-1:0] ext,
  input  logic               rel_next,
  output logic [MASTERS-1:0] ack,
  output logic               hold_ext
);
  localparam int unsigned IDX_CPU = 0;
  localparam int unsigned IDX_DTC = 1;

  own_e             own_q, own_d;
  logic [MASTERS-1:0] owns;
  logic [MASTERS-1:0] hold;
  logic [MASTERS-1:0] eligible;

  // Decode the owner register into one acknowledge per master.
  assign owns[IDX_CPU] = (own_q == OWN_CPU);
  assign owns[IDX_DTC] = (own_q == OWN_DTC);

  genvar g;
  generate
    for (g = 0; g < MASTERS; g++) begin : g_master
      assign hold[g]     = owns[g] && req[g];
      assign eligible[g] = req[g] && !(ext[g] && rel_next);
    end
  endgenerate

  assign hold_ext = |(hold & ext);

  // Owner keeps the bus while requesting; otherwise the data engine outranks the processor.
  always_comb begin
    own_d = OWN_IDLE;
    if (hold[IDX_DTC])          own_d = OWN_DTC;
    else if (hold[IDX_CPU])     own_d = OWN_CPU;
    else if (eligible[IDX_DTC]) own_d = OWN_DTC;
    else if (eligible[IDX_CPU]) own_d = OWN_CPU;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) own_q <= OWN_IDLE;
    else        own_q <= own_d;
  end

  assign ack = owns;

  // R5
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  // R4
  dtc_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[IDX_DTC] && req[IDX_DTC]) |=> ack[IDX_DTC]);

  // R4
  cpu_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[IDX_CPU] && req[IDX_CPU]) |=> ack[IDX_CPU]);

  // R3
  dtc_wins_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack == '0 && req[IDX_CPU] && req[IDX_DTC] && !ext[IDX_DTC]) |=> ack[IDX_DTC]);
endmodule

// File: rtl/busown_arbiter.sv
module busown_arbiter #(
  parameter int unsigned       MASK_W     = 24,
  parameter logic [MASK_W-1:0] STOP_ALL_A = 24'hFFFFFF,
  parameter logic [MASK_W-1:0] STOP_ALL_B = 24'hEFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_ext,
  output logic              cpu_ack,
  input  logic              dtc_req,
  input  logic              dtc_ext,
  output logic              dtc_ack,
  input  logic              xrel_req,
  output logic              xrel_ack,
  input  logic              sleep_i,
  input  logic [MASK_W-1:0] stop_mask
);
  localparam int unsigned MASTERS = 2;

  logic [MASTERS-1:0] req_v, ext_v, ack_v;
  logic               hold_ext;
  logic               rel_next;

  assign req_v = {dtc_req, cpu_req};
  assign ext_v = {dtc_ext, cpu_ext};

  busown_release #(
    .MASK_W     (MASK_W),
    .STOP_ALL_A (STOP_ALL_A),
    .STOP_ALL_B (STOP_ALL_B)
  ) u_release (
    .clk       (clk),
    .rst_n     (rst_n),
    .xrel_req  (xrel_req),
    .sleep_i   (sleep_i),
    .stop_mask (stop_mask),
    .hold_ext  (hold_ext),
    .rel_next  (rel_next),
    .rel_ack   (xrel_ack)
  );

  busown_select #(
    .MASTERS (MASTERS)
  ) u_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_v),
    .ext      (ext_v),
    .rel_next (rel_next),
    .ack      (ack_v),
    .hold_ext (hold_ext)
  );

  assign cpu_ack = ack_v[0];
  assign dtc_ack = ack_v[1];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> !(cpu_ack || dtc_ack || xrel_ack));

  // R6
  cpu_ext_vs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xrel_ack && cpu_ack && cpu_req && cpu_ext));

  // R6
  dtc_ext_vs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xrel_ack && dtc_ack && dtc_req && dtc_ext));

  // R8
  release_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xrel_ack && ((cpu_ack && cpu_req && cpu_ext) || (dtc_ack && dtc_req && dtc_ext))) |=> !xrel_ack);
endmodule

// File: tb/busown_arbiter_bench.sv
module busown_arbiter_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_ext = 1'b0, dtc_req = 1'b0, dtc_ext = 1'b0;
  logic        xrel_req = 1'b0, sleep_i = 1'b0;
  logic [23:0] stop_mask = 24'h000000;
  logic        cpu_ack, dtc_ack, xrel_ack;

  int total = 0;
  int bad = 0;
  int m_cpu = 0, m_dtc = 0, m_rel = 0;
  bit model_on = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  busown_arbiter u_busown_arbiter (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_ext(cpu_ext), .cpu_ack(cpu_ack),
    .dtc_req(dtc_req), .dtc_ext(dtc_ext), .dtc_ack(dtc_ack),
    .xrel_req(xrel_req), .xrel_ack(xrel_ack),
    .sleep_i(sleep_i), .stop_mask(stop_mask)
  );

  // Behavioural reference built from the requirement text.
  always @(posedge clk) begin
    int halt, ext_busy, rel, nc, nd;
    if (!rst_n) begin
      m_cpu <= 0; m_dtc <= 0; m_rel <= 0;
    end else begin
      halt = (sleep_i && (stop_mask == 24'hFFFFFF || stop_mask == 24'hEFFFFF)) ? 1 : 0;
      ext_busy = ((m_cpu == 1 && cpu_req && cpu_ext) || (m_dtc == 1 && dtc_req && dtc_ext)) ? 1 : 0;
      rel = 0;
      if (halt == 0 && xrel_req) begin
        if (m_rel == 1) rel = 1;
        else if (ext_busy == 0) rel = 1;
      end
      nc = 0; nd = 0;
      if (m_dtc == 1 && dtc_req) nd = 1;
      else if (m_cpu == 1 && cpu_req) nc = 1;
      else if (dtc_req && !(dtc_ext && rel == 1)) nd = 1;
      else if (cpu_req && !(cpu_ext && rel == 1)) nc = 1;
      m_cpu <= nc; m_dtc <= nd; m_rel <= rel;
    end
  end

  task automatic check(input string tag, input logic act, input int exp);
    total++;
    if (act !== exp[0]) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare with the model on every falling edge.
  always @(negedge clk) begin
    if (model_on) begin
      check("R5 model cpu_ack", cpu_ack, m_cpu);
      check("R5 model dtc_ack", dtc_ack, m_dtc);
      check("R11 model xrel_ack", xrel_ack, m_rel);
    end
  end

  // Drive after the comparison in the same falling edge; the next falling edge shows the result.
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic drive_random();
    if (!cpu_req) begin
      if ($urandom_range(2) == 0) begin cpu_req = 1'b1; cpu_ext = 1'($urandom_range(1)); end
    end else if ((cpu_ack && $urandom_range(3) == 0) || $urandom_range(15) == 0) cpu_req = 1'b0;
    if (!dtc_req) begin
      if ($urandom_range(2) == 0) begin dtc_req = 1'b1; dtc_ext = 1'($urandom_range(1)); end
    end else if ((dtc_ack && $urandom_range(3) == 0) || $urandom_range(15) == 0) dtc_req = 1'b0;
    if (!xrel_req) begin
      if ($urandom_range(3) == 0) xrel_req = 1'b1;
    end else if ((xrel_ack && $urandom_range(3) == 0) || $urandom_range(9) == 0) xrel_req = 1'b0;
    if ($urandom_range(19) == 0) sleep_i = ~sleep_i;
    if ($urandom_range(9) == 0) begin
      case ($urandom_range(3))
        0: stop_mask = 24'hFFFFFF;
        1: stop_mask = 24'hEFFFFF;
        2: stop_mask = 24'hFFFFFE;
        default: stop_mask = 24'($urandom);
      endcase
    end
  endtask

  initial begin
    repeat (3) step();
    check("R1 cpu_ack in reset", cpu_ack, 0);
    check("R1 dtc_ack in reset", dtc_ack, 0);
    check("R1 xrel_ack in reset", xrel_ack, 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    step();

    // R2 grant latency
    cpu_req = 1'b1; cpu_ext = 1'b0; step();
    check("R2 cpu granted", cpu_ack, 1);
    // R4 no preemption, handover
    dtc_req = 1'b1; step();
    check("R4 cpu kept", cpu_ack, 1);
    check("R4 dtc waits", dtc_ack, 0);
    cpu_req = 1'b0; step();
    check("R4 cpu released", cpu_ack, 0);
    check("R4 dtc handed over", dtc_ack, 1);
    dtc_req = 1'b0; step();
    check("R4 dtc released", dtc_ack, 0);

    // R3 tie
    cpu_req = 1'b1; dtc_req = 1'b1; dtc_ext = 1'b0; step();
    check("R3 dtc wins", dtc_ack, 1);
    check("R3 cpu waits", cpu_ack, 0);
    dtc_req = 1'b0; step();
    check("R3 cpu next", cpu_ack, 1);
    cpu_req = 1'b0; step();

    // R6 tie between levels
    xrel_req = 1'b1; cpu_req = 1'b1; cpu_ext = 1'b1; step();
    check("R6 release wins", xrel_ack, 1);
    check("R6 cpu ext stalled", cpu_ack, 0);
    // R7 internal-only runs in parallel
    dtc_req = 1'b1; dtc_ext = 1'b0; step();
    check("R7 dtc internal granted", dtc_ack, 1);
    check("R7 release kept", xrel_ack, 1);
    dtc_req = 1'b0; step();
    check("R6 cpu still stalled", cpu_ack, 0);
    check("R11 release held", xrel_ack, 1);
    // R9 stalled access granted when release drops
    xrel_req = 1'b0; step();
    check("R11 release dropped", xrel_ack, 0);
    check("R9 cpu ext granted", cpu_ack, 1);

    // R8 release waits for an external access in progress
    xrel_req = 1'b1; step();
    check("R8 release waits", xrel_ack, 0);
    check("R8 cpu kept", cpu_ack, 1);
    cpu_req = 1'b0; cpu_ext = 1'b0; step();
    check("R8 release after cpu", xrel_ack, 1);
    xrel_req = 1'b0; step();

    // R10 halt patterns and near misses
    xrel_req = 1'b1; sleep_i = 1'b1; stop_mask = 24'hFFFFFF; step();
    check("R10 halt all-ones", xrel_ack, 0);
    stop_mask = 24'hEFFFFF; step();
    check("R10 halt bit20 clear", xrel_ack, 0);
    stop_mask = 24'hFFFFFE; step();
    check("R10 near miss works", xrel_ack, 1);
    stop_mask = 24'hFFFFFF; step();
    check("R10 halt drops ack", xrel_ack, 0);
    sleep_i = 1'b0; step();
    check("R10 awake works", xrel_ack, 1);
    xrel_req = 1'b0; stop_mask = 24'h0; step();

    // Random phase, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      drive_random();
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule